// File: doc/BRIEF.md
# Dual-Clock FIFO Controller with Rewind and Fall-Through Timing

This block manages a small first-in first-out buffer whose write side and read side run on two clocks that have no fixed relation. It holds the storage as an internal register array. It keeps a write pointer and a read pointer, and it produces one status flag for each side. Both pointers cross between the clock domains as Gray code through two-flop synchronisers. The empty condition is worked out in the read domain and the full condition in the write domain.

Two timing behaviours are available, and both are chosen while master reset is held. In standard timing a word stays inside the buffer until a read pulls it onto the output register. In fall-through timing the oldest word moves onto the output by itself, and the read-side flag then reports that the output holds valid data.

A rewind input moves the read pointer back to the first storage location, so the data written since the last reset can be read again. The rewind has a zero-latency variant and a normal-latency variant. A partial reset clears the pointers but keeps every setting that was latched. A master reset clears the pointers and latches the settings again.

Top module: `fifo_rt_ctrl`

## Requirements
- R1: While `rst_ni` is low and each clock has at least one rising edge, `fwft_sel_i` is latched (0 = standard timing, 1 = fall-through timing). Changes on `fwft_sel_i` after reset has been released have no effect.
- R2: In standard timing, `rd_flag_o` is the empty flag (1 = empty). A written word does not appear on `rdata_o` until a read-clock edge with `ren_i` high and the buffer not empty loads it.
- R3: In fall-through timing, `rd_flag_o` is output-ready (1 = valid data on `rdata_o`). The first word written into an empty buffer shows up on `rdata_o`, with `rd_flag_o` high, within four read-clock cycles and without `ren_i`.
- R4: In fall-through timing, while `ren_i` is low the shown word and `rd_flag_o` are held. Each read-clock edge with `ren_i` high moves on to the next word.
- R5: `wr_flag_o` is the full flag (1 = full) in standard timing and input-ready (1 = room) in fall-through timing. The buffer holds DEPTH words, plus the output register in fall-through timing.
- R6: A write while the buffer is full is ignored and leaves the stored data and the write pointer unchanged.
- R7: A read while the buffer is empty is ignored and leaves `rdata_o` and the read pointer unchanged.
- R8: `rt_ni` low on a read-clock edge rewinds reading to storage location 0. After that, further reads return the words in their original order.
- R9: `rt_lat_i` latched low at master reset selects zero latency: the word at location 0 is loaded into `rdata_o` on the same edge that samples `rt_ni` low, and `rd_flag_o` shows data present after that edge.
- R10: `rt_lat_i` latched high selects normal latency: for one read cycle after the rewind edge `rd_flag_o` shows no data, and the word at location 0 is loaded on the next edge.
- R11: `prst_ni` low clears both pointers, the output register and the flags. The latched timing and rewind-latency settings are kept, whatever the pins show during the partial reset.
- R12: A further master reset latches the timing and latency pins again, and the flags take the reset values of the newly chosen timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous for the pointers |
| prst_ni | input | 1 | Partial reset, active low, asynchronous |
| fwft_sel_i | input | 1 | Timing select, sampled during master reset |
| rt_lat_i | input | 1 | Rewind latency select (0 zero, 1 normal), sampled during master reset |
| wen_i | input | 1 | Write enable |
| wdata_i | input | DW | Write data |
| ren_i | input | 1 | Read enable |
| rt_ni | input | 1 | Rewind request, active low |
| rdata_o | output | DW | Output register |
| rd_flag_o | output | 1 | Empty (standard) or output-ready (fall-through) |
| wr_flag_o | output | 1 | Full (standard) or input-ready (fall-through) |

## Verification
The properties take several things about the inputs as given. A rewind is requested only after at least one word has been written, and with fewer than DEPTH writes since the last reset. The write side is idle around a rewind, because the read pointer then jumps by more than one Gray step. The mode pins are stable while master reset is held. Each rewind scenario in the stimulus starts from a fresh master reset, writes four words, drains them, lets the write side go quiet and only then pulses `rt_ni`. Mode pins change only inside a reset, or after it on purpose to show that they are ignored.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef enum logic {TM_STD = 1'b0, TM_FWFT = 1'b1} tmode_e;
  typedef enum logic {RT_ZERO = 1'b0, RT_NORM = 1'b1} rtlat_e;
endpackage

// File: rtl/fifo_rt_sync.sv
module fifo_rt_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fifo_rt_wr.sv
module fifo_rt_wr
  import fifo_rt_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        wclk_i,
  input  logic        mrst_ni,
  input  logic        rst_ni,
  input  logic        fwft_sel_i,
  input  logic        wen_i,
  input  logic [AW:0] rgray_i,
  output logic [AW:0] wbin_o,
  output logic [AW:0] wgray_o,
  output logic        we_o,
  output logic        full_o,
  output logic        wr_flag_o
);
  localparam int PW = AW + 1;

  tmode_e          mode_q;
  logic [PW-1:0]   wbin_q, wbin_d, wgray_q;

  // settings follow the pin while master reset is held
  always_ff @(posedge wclk_i) begin
    if (!mrst_ni) mode_q <= tmode_e'(fwft_sel_i);
  end

  assign full_o = (wgray_q == {~rgray_i[PW-1:PW-2], rgray_i[PW-3:0]});
  assign we_o   = wen_i && !full_o;
  assign wbin_d = we_o ? wbin_q + 1'b1 : wbin_q;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wbin_d ^ (wbin_d >> 1);
    end
  end

  assign wbin_o    = wbin_q;
  assign wgray_o   = wgray_q;
  assign wr_flag_o = (mode_q == TM_FWFT) ? !full_o : full_o;
endmodule

// File: rtl/fifo_rt_rd.sv
module fifo_rt_rd
  import fifo_rt_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          rclk_i,
  input  logic          mrst_ni,
  input  logic          rst_ni,
  input  logic          fwft_sel_i,
  input  logic          rt_lat_i,
  input  logic          ren_i,
  input  logic          rt_ni,
  input  logic [AW:0]   wgray_i,
  input  logic [DW-1:0] mem_q_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          rd_flag_o,
  output logic          fwft_o,
  output logic          zl_o,
  output logic          pend_o
);
  localparam int PW = AW + 1;

  tmode_e        mode_q;
  rtlat_e        lat_q;
  logic [PW-1:0] rbin_q, rbin_d, rgray_q;
  logic          ordy_q, ordy_d, pend_q, pend_d, load;
  logic [DW-1:0] rdata_q;
  logic          fwft, zl, mem_empty;

  always_ff @(posedge rclk_i) begin
    if (!mrst_ni) begin
      mode_q <= tmode_e'(fwft_sel_i);
      lat_q  <= rtlat_e'(rt_lat_i);
    end
  end

  assign fwft      = (mode_q == TM_FWFT);
  assign zl        = (lat_q == RT_ZERO);
  assign mem_empty = (rgray_q == wgray_i);

  always_comb begin
    rbin_d  = rbin_q;
    ordy_d  = ordy_q;
    pend_d  = 1'b0;
    load    = 1'b0;
    raddr_o = rbin_q[AW-1:0];
    if (!rt_ni) begin
      if (zl) begin
        // rewind and present location 0 on this edge
        raddr_o = '0;
        load    = 1'b1;
        rbin_d  = PW'(1);
        ordy_d  = 1'b1;
      end else begin
        rbin_d  = '0;
        ordy_d  = 1'b0;
        pend_d  = 1'b1;
      end
    end else if (pend_q) begin
      load   = 1'b1;
      rbin_d = PW'(1);
      ordy_d = 1'b1;
    end else if (fwft) begin
      if ((!ordy_q || ren_i) && !mem_empty) begin
        load   = 1'b1;
        rbin_d = rbin_q + 1'b1;
        ordy_d = 1'b1;
      end else if (ren_i) begin
        ordy_d = 1'b0;
      end
    end else if (ren_i && !mem_empty) begin
      load   = 1'b1;
      rbin_d = rbin_q + 1'b1;
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      ordy_q  <= 1'b0;
      pend_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
      ordy_q  <= ordy_d;
      pend_q  <= pend_d;
      if (load) rdata_q <= mem_q_i;
    end
  end

  assign rgray_o   = rgray_q;
  assign rdata_o   = rdata_q;
  assign rd_flag_o = fwft ? ordy_q : (mem_empty || pend_q);
  assign fwft_o    = fwft;
  assign zl_o      = zl;
  assign pend_o    = pend_q;
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          fwft_sel_i,
  input  logic          rt_lat_i,
  input  logic          wen_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ren_i,
  input  logic          rt_ni,
  output logic [DW-1:0] rdata_o,
  output logic          rd_flag_o,
  output logic          wr_flag_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          ptr_rst_n;
  logic [PW-1:0] wptr_bin, wgray, wgray_s, rgray, rgray_s;
  logic          we, wfull, fwft_rd, zl_rd, rt_pend;
  logic [AW-1:0] raddr;
  logic [DW-1:0] mem_q;

  assign ptr_rst_n = rst_ni & prst_ni;

  fifo_rt_wr #(.AW(AW)) u_wr (
    .wclk_i(wclk_i), .mrst_ni(rst_ni), .rst_ni(ptr_rst_n), .fwft_sel_i(fwft_sel_i),
    .wen_i(wen_i), .rgray_i(rgray_s), .wbin_o(wptr_bin), .wgray_o(wgray),
    .we_o(we), .full_o(wfull), .wr_flag_o(wr_flag_o)
  );

  fifo_rt_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(wptr_bin[AW-1:0]), .wdata_i(wdata_i),
    .raddr_i(raddr), .rdata_o(mem_q)
  );

  fifo_rt_sync #(.W(PW)) u_w2r (
    .clk_i(rclk_i), .rst_ni(ptr_rst_n), .d_i(wgray), .q_o(wgray_s)
  );

  fifo_rt_sync #(.W(PW)) u_r2w (
    .clk_i(wclk_i), .rst_ni(ptr_rst_n), .d_i(rgray), .q_o(rgray_s)
  );

  fifo_rt_rd #(.AW(AW), .DW(DW)) u_rd (
    .rclk_i(rclk_i), .mrst_ni(rst_ni), .rst_ni(ptr_rst_n), .fwft_sel_i(fwft_sel_i),
    .rt_lat_i(rt_lat_i), .ren_i(ren_i), .rt_ni(rt_ni), .wgray_i(wgray_s),
    .mem_q_i(mem_q), .raddr_o(raddr), .rgray_o(rgray), .rdata_o(rdata_o),
    .rd_flag_o(rd_flag_o), .fwft_o(fwft_rd), .zl_o(zl_rd), .pend_o(rt_pend)
  );
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int PW = 5,
  parameter int DW = 32
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          prst_ni,
  input logic          wen_i,
  input logic          ren_i,
  input logic          rt_ni,
  input logic [DW-1:0] rdata_o,
  input logic          rd_flag_o,
  input logic          wfull,
  input logic [PW-1:0] wptr_bin,
  input logic          fwft_rd,
  input logic          zl_rd,
  input logic          rt_pend
);
  a_r6_full_write_ignored: assert property (@(posedge wclk_i) disable iff (!rst_ni || !prst_ni)
    wfull && wen_i |=> $stable(wptr_bin));

  a_r7_empty_read_ignored: assert property (@(posedge rclk_i) disable iff (!rst_ni || !prst_ni)
    !fwft_rd && rd_flag_o && ren_i && rt_ni && !rt_pend |=> $stable(rdata_o));

  a_r4_fwft_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni || !prst_ni)
    fwft_rd && rd_flag_o && !ren_i && rt_ni && !rt_pend |=> rd_flag_o && $stable(rdata_o));

  a_r9_zero_lat_ready: assert property (@(posedge rclk_i) disable iff (!rst_ni || !prst_ni)
    fwft_rd && zl_rd && !rt_ni |=> rd_flag_o);

  a_r10_normal_lat_gap: assert property (@(posedge rclk_i) disable iff (!rst_ni || !prst_ni)
    !zl_rd && !rt_ni |=> (rd_flag_o == !fwft_rd));

  a_r11_mode_kept: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !prst_ni |=> $stable(fwft_rd) && $stable(zl_rd));
endmodule

bind fifo_rt_ctrl fifo_rt_chk #(.PW(PW), .DW(DW)) i_fifo_rt_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .prst_ni(prst_ni),
  .wen_i(wen_i), .ren_i(ren_i), .rt_ni(rt_ni), .rdata_o(rdata_o),
  .rd_flag_o(rd_flag_o), .wfull(wfull), .wptr_bin(wptr_bin),
  .fwft_rd(fwft_rd), .zl_rd(zl_rd), .rt_pend(rt_pend)
);

// File: tb/test_fifo_rt_ctrl.sv
`timescale 1ns/1ps
module test_fifo_rt_ctrl;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0, rt_lat = 1'b1;
  logic wen = 1'b0, ren = 1'b0, rt_n = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_flag, wr_flag;
  int total = 0, bad = 0;

  always #4 wclk = ~wclk;
  initial begin
    #3;
    forever #6.5 rclk = ~rclk;
  end

  fifo_rt_ctrl #(.DW(DW), .DEPTH(DEPTH)) i_fifo_rt_ctrl (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .prst_ni(prst_n),
    .fwft_sel_i(fwft_sel), .rt_lat_i(rt_lat), .wen_i(wen), .wdata_i(wdata),
    .ren_i(ren), .rt_ni(rt_n), .rdata_o(rdata), .rd_flag_o(rd_flag), .wr_flag_o(wr_flag)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic mreset(input logic fw, input logic lat);
    @(negedge wclk);
    rst_n = 1'b0; prst_n = 1'b1; fwft_sel = fw; rt_lat = lat;
    wen = 1'b0; ren = 1'b0; rt_n = 1'b1;
    repeat (4) @(negedge rclk);
    @(negedge wclk); #1.25;
    rst_n = 1'b1;
    repeat (3) @(negedge rclk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge wclk); wen = 1'b1; wdata = d;
    @(negedge wclk); wen = 1'b0;
  endtask

  task automatic pop();
    @(negedge rclk); ren = 1'b1;
    @(negedge rclk); ren = 1'b0;
  endtask

  task automatic wait_rd(input logic v, input int max, output int n);
    n = 0;
    for (int i = 0; i < max; i++) begin
      @(negedge rclk);
      n++;
      if (rd_flag == v) break;
    end
  endtask

  task automatic rewind();
    @(negedge rclk); rt_n = 1'b0;
    @(negedge rclk); rt_n = 1'b1;
  endtask

  task automatic t_reset();
    mreset(1'b0, 1'b1);
    chk("R12 std empty after reset", DW'(rd_flag), DW'(1));
    chk("R12 std not full after reset", DW'(wr_flag), DW'(0));
    chk("R12 rdata after reset", rdata, '0);
    mreset(1'b1, 1'b1);
    chk("R12 fwft not ready after reset", DW'(rd_flag), DW'(0));
    chk("R12 fwft input ready after reset", DW'(wr_flag), DW'(1));
  endtask

  task automatic t_std_basic();
    mreset(1'b0, 1'b1);
    fwft_sel = 1'b1; // R1: ignored after reset
    for (int i = 0; i < 3; i++) wr(32'hA000_0000 + i);
    repeat (6) @(negedge rclk);
    chk("R2 not empty after writes", DW'(rd_flag), DW'(0));
    chk("R1 R2 no data without read", rdata, '0);
    for (int i = 0; i < 3; i++) begin
      pop();
      chk("R2 read order", rdata, 32'hA000_0000 + i);
    end
    chk("R2 empty after drain", DW'(rd_flag), DW'(1));
    pop();
    chk("R7 read on empty keeps data", rdata, 32'hA000_0002);
    chk("R7 still empty", DW'(rd_flag), DW'(1));
    fwft_sel = 1'b0;
  endtask

  task automatic t_std_full();
    mreset(1'b0, 1'b1);
    for (int i = 0; i < DEPTH; i++) wr(32'hB000_0000 + i);
    chk("R5 full flag at depth", DW'(wr_flag), DW'(1));
    wr(32'hDEAD_BEEF);
    chk("R6 still full after extra write", DW'(wr_flag), DW'(1));
    repeat (4) @(negedge rclk);
    for (int i = 0; i < DEPTH; i++) begin
      pop();
      chk("R6 stored data intact", rdata, 32'hB000_0000 + i);
    end
    chk("R6 nothing beyond depth", DW'(rd_flag), DW'(1));
    repeat (4) @(negedge wclk);
    chk("R5 full clears after drain", DW'(wr_flag), DW'(0));
  endtask

  task automatic t_fwft_basic();
    int n;
    mreset(1'b1, 1'b1);
    wr(32'hC100_0000);
    chk("R3 not ready at write", DW'(rd_flag), DW'(0));
    wait_rd(1'b1, 4, n);
    chk("R3 ready within four cycles", DW'(rd_flag), DW'(1));
    chk("R3 first word shown", rdata, 32'hC100_0000);
    wr(32'hC100_0001);
    wr(32'hC100_0002);
    repeat (5) @(negedge rclk);
    chk("R4 held without read", rdata, 32'hC100_0000);
    chk("R4 flag held", DW'(rd_flag), DW'(1));
    pop();
    chk("R4 advance", rdata, 32'hC100_0001);
    pop();
    chk("R4 advance", rdata, 32'hC100_0002);
    pop();
    chk("R7 fwft empty not ready", DW'(rd_flag), DW'(0));
    pop();
    chk("R7 fwft read on empty keeps data", rdata, 32'hC100_0002);
  endtask

  task automatic t_fwft_ir();
    mreset(1'b1, 1'b1);
    for (int i = 0; i < DEPTH; i++) wr(32'hD000_0000 + i);
    repeat (16) @(negedge wclk);
    chk("R5 room while output holds one", DW'(wr_flag), DW'(1));
    wr(32'hD000_0000 + DEPTH);
    chk("R5 input ready low when full", DW'(wr_flag), DW'(0));
    wr(32'hDEAD_BEEF);
    chk("R6 fwft stays full", DW'(wr_flag), DW'(0));
    repeat (4) @(negedge rclk);
    for (int i = 0; i <= DEPTH; i++) begin
      chk("R6 fwft data intact", rdata, 32'hD000_0000 + i);
      pop();
    end
    chk("R6 fwft nothing extra", DW'(rd_flag), DW'(0));
  endtask

  task automatic t_rt(input logic fw, input logic lat);
    int n;
    logic [DW-1:0] base;
    base = 32'hE000_0000 | (DW'(fw) << 8) | (DW'(lat) << 4);
    mreset(fw, lat);
    for (int i = 0; i < 4; i++) wr(base + i);
    repeat (5) @(negedge rclk);
    if (fw) begin
      wait_rd(1'b1, 4, n);
      chk("R8 drain first", rdata, base);
      for (int i = 1; i < 4; i++) begin
        pop();
        chk("R8 drain", rdata, base + i);
      end
      pop();
    end else begin
      for (int i = 0; i < 4; i++) begin
        pop();
        chk("R8 drain", rdata, base + i);
      end
    end
    repeat (3) @(negedge rclk);
    rewind();
    if (!lat) begin
      chk("R9 same-edge word", rdata, base);
      chk("R9 flag shows data", DW'(rd_flag), DW'(fw));
    end else begin
      chk("R10 gap flag", DW'(rd_flag), DW'(!fw));
      @(negedge rclk);
      chk("R10 word one cycle later", rdata, base);
      chk("R10 flag after gap", DW'(rd_flag), DW'(fw));
    end
    for (int i = 1; i < 4; i++) begin
      pop();
      chk("R8 reread order", rdata, base + i);
    end
    if (fw) pop();
    chk("R8 end after reread", DW'(rd_flag), DW'(!fw));
  endtask

  task automatic t_prst();
    int n;
    mreset(1'b1, 1'b1);
    wr(32'hF000_0000);
    wr(32'hF000_0001);
    wait_rd(1'b1, 6, n);
    @(negedge wclk); #1.25;
    prst_n = 1'b0; fwft_sel = 1'b0; rt_lat = 1'b0;
    repeat (3) @(negedge rclk);
    chk("R11 flags cleared, fwft kept", DW'(rd_flag), DW'(0));
    chk("R11 input ready in reset", DW'(wr_flag), DW'(1));
    chk("R11 output cleared", rdata, '0);
    @(negedge wclk); #1.25;
    prst_n = 1'b1;
    repeat (3) @(negedge rclk);
    wr(32'hF100_0000);
    wait_rd(1'b1, 5, n);
    chk("R11 fwft kept after partial reset", rdata, 32'hF100_0000);
    repeat (3) @(negedge rclk);
    rewind();
    chk("R11 normal latency kept", DW'(rd_flag), DW'(0));
    @(negedge rclk);
    chk("R11 rewind to location 0", rdata, 32'hF100_0000);
    rt_lat = 1'b1;
  endtask

  task automatic t_relatch();
    mreset(1'b0, 1'b1);
    wr(32'h1234_5678);
    repeat (6) @(negedge rclk);
    chk("R12 standard after relatch", rdata, '0);
    chk("R12 not empty", DW'(rd_flag), DW'(0));
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_std_basic();
    t_std_full();
    t_fwft_basic();
    t_fwft_ir();
    t_rt(1'b0, 1'b0);
    t_rt(1'b0, 1'b1);
    t_rt(1'b1, 1'b0);
    t_rt(1'b1, 1'b1);
    t_prst();
    t_relatch();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule